// File: doc/BRIEF.md
# UART FIFO Status Tracker

This block holds the receive and transmit byte queues of a UART and reports their state. On the receive side, a serial receiver offers each finished byte. The block stores it and presents the oldest stored byte to the CPU read port. On the transmit side, the CPU writes bytes into a queue, and the block hands them one at a time to the transmit shift register. The shift register sends a one-cycle pulse when the stop bit of the byte it holds has left the line.

For each direction the block reports an occupancy count, an empty flag, a full flag and a sticky overflow flag. The CPU clears an overflow flag by pulsing its clear input, which stands for writing 1 to that flag. A transmitter-idle flag is high only when the transmit queue is empty and the last loaded byte has finished its stop bit.

All byte transfers use valid/ready. A transfer happens on a rising edge where both valid and ready are high.
- The CPU read port and the shift-register port follow the normal rule: valid, once raised, stays up until it is taken.
- The receiver and the CPU write port cannot be stalled. `rx_in_ready` and `tx_wr_ready` are reports of free space, not holds. A byte offered while ready is low is dropped and sets that direction's overflow flag.

Top module: `uart_fifo_status`

## Requirements
- R1: After reset both counts are 0, `rx_empty`, `tx_empty` and `tx_idle` are 1, and `rx_full`, `tx_full`, `rx_ovf` and `tx_ovf` are 0.
- R2: The receive count rises by one on the cycle after a byte is accepted. It falls by one after a CPU read handshake. It is unchanged when both happen in the same cycle. Bytes reach `rd_data` in arrival order.
- R3: `rx_full` is 1 exactly when the receive count equals DEPTH, and `rx_in_ready` is its inverse. `rx_empty` is 1 exactly when the count is 0: it rises after the last stored byte is read and falls after any new byte is accepted. `rd_valid` equals `!rx_empty`.
- R4: A byte offered on `rx_in_valid` while `rx_full` is 1 is discarded. The count and the stored bytes stay unchanged, and `rx_ovf` is 1 from the next cycle. This holds even when a read happens in the same cycle.
- R5: `rx_ovf` stays 1 until a cycle with `clr_rx_ovf` high and no new drop. When a drop and a clear happen in the same cycle, the flag stays set.
- R6: The transmit count rises after a CPU write handshake and falls after a shift-register handshake. It is unchanged when both occur together. Bytes leave on `sh_data` in write order.
- R7: `tx_full` is 1 exactly when the transmit count equals DEPTH, and `tx_wr_ready` is its inverse. `tx_empty` is 1 exactly when the count is 0. `sh_valid` equals `!tx_empty`.
- R8: A CPU write while `tx_full` is 1 is discarded and sets `tx_ovf` from the next cycle. `tx_ovf` clears only on `clr_tx_ovf` without a simultaneous drop.
- R9: A shift-register handshake marks the line busy from the next cycle. A `sh_stop_done` pulse clears it, unless a new load happens in the same cycle. `tx_idle` is 1 exactly when the transmit count is 0 and the line is not busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_in_valid | input | 1 | Receiver offers a finished byte |
| rx_in_data | input | 8 | Received byte |
| rx_in_ready | output | 1 | Receive queue has room (advisory) |
| rd_valid | output | 1 | A received byte is available to the CPU |
| rd_ready | input | 1 | CPU reads the presented byte |
| rd_data | output | 8 | Oldest received byte |
| tx_wr_valid | input | 1 | CPU writes a byte to transmit |
| tx_wr_data | input | 8 | Byte to transmit |
| tx_wr_ready | output | 1 | Transmit queue has room (advisory) |
| sh_valid | output | 1 | A byte is waiting for the shift register |
| sh_ready | input | 1 | Shift register loads the presented byte |
| sh_data | output | 8 | Oldest byte to transmit |
| sh_stop_done | input | 1 | Stop bit of the loaded byte has been sent |
| clr_rx_ovf | input | 1 | Write-1-to-clear for the receive overflow flag |
| clr_tx_ovf | input | 1 | Write-1-to-clear for the transmit overflow flag |
| rx_count | output | $clog2(DEPTH+1) | Receive occupancy |
| rx_empty | output | 1 | Receive queue empty |
| rx_full | output | 1 | Receive queue full |
| rx_ovf | output | 1 | Sticky receive overflow |
| tx_count | output | $clog2(DEPTH+1) | Transmit occupancy |
| tx_empty | output | 1 | Transmit queue empty |
| tx_full | output | 1 | Transmit queue full |
| tx_ovf | output | 1 | Sticky transmit overflow |
| tx_idle | output | 1 | Queue empty and last stop bit sent |

## Verification
The bench builds the block with DEPTH at 16. At that depth, filling either queue to the top takes only a few dozen cycles. This brings repeated full-queue drops, a read or load coinciding with a drop, and clears that land on a drop cycle well within a short random run. With 16 entries, which is a power of two, the pointer wrap takes the natural-overflow variant, and long runs wrap the pointers many times. Random phases that favour filling, draining or balance move both counts across their whole range. Random stop pulses overlap with new loads, so the busy-line rule is exercised around every empty-queue transition.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  function automatic bit is_pow2(input int n);
    return (n > 0) && ((n & (n - 1)) == 0);
  endfunction
endpackage

// File: rtl/byte_fifo.sv
module byte_fifo
  import uart_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  byte_t         in_data,
  output logic          in_ready,
  output logic          dropped,
  output logic          out_valid,
  input  logic          out_ready,
  output byte_t         out_data,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  byte_t         store [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
  logic          push, pop;

  assign full      = (count == CW'(DEPTH));
  assign empty     = (count == '0);
  assign in_ready  = !full;
  assign out_valid = !empty;
  assign push      = in_valid && in_ready;
  assign pop       = out_valid && out_ready;
  assign dropped   = in_valid && !in_ready;
  assign out_data  = store[rd_ptr];

  generate
    if (is_pow2(DEPTH)) begin : g_wrap_free
      assign wr_nxt = wr_ptr + AW'(1);
      assign rd_nxt = rd_ptr + AW'(1);
    end else begin : g_wrap_cmp
      assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
      assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (push) store[wr_ptr] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= wr_nxt;
      if (pop)  rd_ptr <= rd_nxt;
      case ({push, pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !(out_valid && out_ready)) |=> count == $past(count) + CW'(1)); // R2
  AST_POP_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !(in_valid && in_ready)) |=> count == $past(count) - CW'(1)); // R2
  AST_DROP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && full && !out_ready) |=> count == $past(count)); // R4
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH)); // R3
endmodule

// File: rtl/sticky_flag.sv
module sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end

  AST_STICKY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> q); // R5
  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (q && !clr) |=> q); // R5
endmodule

// File: rtl/tx_line_tracker.sv
module tx_line_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic stop_done,
  input  logic queue_empty,
  output logic idle
);
  logic busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         busy <= 1'b0;
    else if (load)      busy <= 1'b1;
    else if (stop_done) busy <= 1'b0;
  end

  assign idle = queue_empty && !busy;

  AST_LOAD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !idle); // R9
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && !stop_done && !load) |=> (!idle || $past(!queue_empty))); // R9
endmodule

// File: rtl/uart_fifo_status.sv
module uart_fifo_status
  import uart_fifo_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         rx_in_valid,
  input  logic [7:0]                   rx_in_data,
  output logic                         rx_in_ready,
  output logic                         rd_valid,
  input  logic                         rd_ready,
  output logic [7:0]                   rd_data,
  input  logic                         tx_wr_valid,
  input  logic [7:0]                   tx_wr_data,
  output logic                         tx_wr_ready,
  output logic                         sh_valid,
  input  logic                         sh_ready,
  output logic [7:0]                   sh_data,
  input  logic                         sh_stop_done,
  input  logic                         clr_rx_ovf,
  input  logic                         clr_tx_ovf,
  output logic [$clog2(DEPTH+1)-1:0]   rx_count,
  output logic                         rx_empty,
  output logic                         rx_full,
  output logic                         rx_ovf,
  output logic [$clog2(DEPTH+1)-1:0]   tx_count,
  output logic                         tx_empty,
  output logic                         tx_full,
  output logic                         tx_ovf,
  output logic                         tx_idle
);
  localparam int CW = $clog2(DEPTH + 1);

  logic rx_drop, tx_drop;

  byte_fifo #(.DEPTH(DEPTH), .CW(CW)) u_rx_q (
    .clk(clk), .rst_n(rst_n),
    .in_valid(rx_in_valid), .in_data(rx_in_data), .in_ready(rx_in_ready),
    .dropped(rx_drop),
    .out_valid(rd_valid), .out_ready(rd_ready), .out_data(rd_data),
    .count(rx_count), .full(rx_full), .empty(rx_empty)
  );

  byte_fifo #(.DEPTH(DEPTH), .CW(CW)) u_tx_q (
    .clk(clk), .rst_n(rst_n),
    .in_valid(tx_wr_valid), .in_data(tx_wr_data), .in_ready(tx_wr_ready),
    .dropped(tx_drop),
    .out_valid(sh_valid), .out_ready(sh_ready), .out_data(sh_data),
    .count(tx_count), .full(tx_full), .empty(tx_empty)
  );

  sticky_flag u_rx_ovf (
    .clk(clk), .rst_n(rst_n), .set(rx_drop), .clr(clr_rx_ovf), .q(rx_ovf)
  );

  sticky_flag u_tx_ovf (
    .clk(clk), .rst_n(rst_n), .set(tx_drop), .clr(clr_tx_ovf), .q(tx_ovf)
  );

  tx_line_tracker u_line (
    .clk(clk), .rst_n(rst_n),
    .load(sh_valid && sh_ready), .stop_done(sh_stop_done),
    .queue_empty(tx_empty), .idle(tx_idle)
  );

  AST_RX_DROP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_in_valid && rx_full) |=> rx_ovf); // R4
  AST_TX_DROP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr_valid && tx_full) |=> tx_ovf); // R8
  AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_idle |-> (tx_count == '0)); // R9
  AST_RX_FILL_CLEARS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_in_valid && rx_empty) |=> !rx_empty); // R3
endmodule

// File: tb/uart_fifo_status_tb.sv
module uart_fifo_status_tb;
  localparam int D  = 16;
  localparam int CW = $clog2(D + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic rx_in_valid = 0, rd_ready = 0, tx_wr_valid = 0, sh_ready = 0;
  logic sh_stop_done = 0, clr_rx_ovf = 0, clr_tx_ovf = 0;
  logic [7:0] rx_in_data = 0, tx_wr_data = 0;
  logic rx_in_ready, rd_valid, tx_wr_ready, sh_valid;
  logic [7:0] rd_data, sh_data;
  logic [CW-1:0] rx_count, tx_count;
  logic rx_empty, rx_full, rx_ovf, tx_empty, tx_full, tx_ovf, tx_idle;

  uart_fifo_status #(.DEPTH(D)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .rx_in_valid(rx_in_valid), .rx_in_data(rx_in_data), .rx_in_ready(rx_in_ready),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .tx_wr_valid(tx_wr_valid), .tx_wr_data(tx_wr_data), .tx_wr_ready(tx_wr_ready),
    .sh_valid(sh_valid), .sh_ready(sh_ready), .sh_data(sh_data),
    .sh_stop_done(sh_stop_done), .clr_rx_ovf(clr_rx_ovf), .clr_tx_ovf(clr_tx_ovf),
    .rx_count(rx_count), .rx_empty(rx_empty), .rx_full(rx_full), .rx_ovf(rx_ovf),
    .tx_count(tx_count), .tx_empty(tx_empty), .tx_full(tx_full), .tx_ovf(tx_ovf),
    .tx_idle(tx_idle)
  );

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;

  byte unsigned rxq[$], txq[$];
  bit m_rx_ovf = 0, m_tx_ovf = 0, m_busy = 0;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s cycle=%0d actual=%0d expected=%0d", tag, cyc, act, exp);
    end
  endtask

  function automatic bit pct(input int p);
    return ($urandom % 100) < p;
  endfunction

  function automatic bit model_idle();
    return (txq.size() == 0) && !m_busy;
  endfunction

  task automatic check_all();
    chk("R2 rx_count", rx_count, rxq.size());
    chk("R3 rx_empty", rx_empty, rxq.size() == 0);
    chk("R3 rx_full", rx_full, rxq.size() == D);
    chk("R3 rx_in_ready", rx_in_ready, rxq.size() != D);
    chk("R3 rd_valid", rd_valid, rxq.size() != 0);
    if (rxq.size() != 0) chk("R2 rd_data order", rd_data, rxq[0]);
    chk("R5 rx_ovf", rx_ovf, m_rx_ovf);
    chk("R6 tx_count", tx_count, txq.size());
    chk("R7 tx_empty", tx_empty, txq.size() == 0);
    chk("R7 tx_full", tx_full, txq.size() == D);
    chk("R7 tx_wr_ready", tx_wr_ready, txq.size() != D);
    chk("R7 sh_valid", sh_valid, txq.size() != 0);
    if (txq.size() != 0) chk("R6 sh_data order", sh_data, txq[0]);
    chk("R8 tx_ovf", tx_ovf, m_tx_ovf);
    chk("R9 tx_idle", tx_idle, model_idle());
  endtask

  task automatic finish_run();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      finish_run();
    end
  end

  initial begin
    int rx_push_p, rx_pop_p, tx_push_p, tx_pop_p;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: state right after reset
    chk("R1 rx_count", rx_count, 0);
    chk("R1 tx_count", tx_count, 0);
    chk("R1 rx_empty", rx_empty, 1);
    chk("R1 tx_empty", tx_empty, 1);
    chk("R1 rx_full", rx_full, 0);
    chk("R1 tx_full", tx_full, 0);
    chk("R1 rx_ovf", rx_ovf, 0);
    chk("R1 tx_ovf", tx_ovf, 0);
    chk("R1 tx_idle", tx_idle, 1);

    for (int i = 0; i < 4000; i++) begin
      bit rpush, rdrop, rpop, tpush, tdrop, tpop;
      check_all();
      if (i < 60) begin
        // directed: fill both queues past the top (R4, R8), no draining
        rx_push_p = 100; rx_pop_p = 0; tx_push_p = 100; tx_pop_p = 0;
      end else if (i < 90) begin
        // directed: reads/loads on drop cycles at full (R4, R8)
        rx_push_p = 100; rx_pop_p = 50; tx_push_p = 100; tx_pop_p = 50;
      end else if (i % 200 == 0) begin
        case ($urandom % 4)
          0: begin rx_push_p = 90; rx_pop_p = 15; tx_push_p = 85; tx_pop_p = 20; end
          1: begin rx_push_p = 15; rx_pop_p = 85; tx_push_p = 10; tx_pop_p = 80; end
          2: begin rx_push_p = 50; rx_pop_p = 50; tx_push_p = 50; tx_pop_p = 50; end
          default: begin rx_push_p = 70; rx_pop_p = 70; tx_push_p = 30; tx_pop_p = 70; end
        endcase
      end
      rx_in_valid  = pct(rx_push_p);
      rx_in_data   = 8'($urandom);
      rd_ready     = pct(rx_pop_p);
      tx_wr_valid  = pct(tx_push_p);
      tx_wr_data   = 8'($urandom);
      sh_ready     = pct(tx_pop_p);
      sh_stop_done = pct(30);
      clr_rx_ovf   = (i >= 40) && pct(8);
      clr_tx_ovf   = (i >= 40) && pct(8);

      rpush = rx_in_valid && (rxq.size() < D);
      rdrop = rx_in_valid && (rxq.size() == D);
      rpop  = rd_ready && (rxq.size() > 0);
      tpush = tx_wr_valid && (txq.size() < D);
      tdrop = tx_wr_valid && (txq.size() == D);
      tpop  = sh_ready && (txq.size() > 0);
      if (rpop)  void'(rxq.pop_front());
      if (rpush) rxq.push_back(rx_in_data);
      if (tpop)  void'(txq.pop_front());
      if (tpush) txq.push_back(tx_wr_data);
      if (rdrop) m_rx_ovf = 1; else if (clr_rx_ovf) m_rx_ovf = 0;
      if (tdrop) m_tx_ovf = 1; else if (clr_tx_ovf) m_tx_ovf = 0;
      if (tpop) m_busy = 1; else if (sh_stop_done) m_busy = 0;
      @(negedge clk);
    end
    check_all();
    finish_run();
  end
endmodule